// File: doc/BRIEF.md
# Calibrated Seconds Divider with Test Pin

This block turns a 32768 Hz oscillator enable into a one-clock 1 Hz tick. A signed calibration value trims the rate in the digital domain. It does this by removing or inserting oscillator counts at the divide-by-256 stage of the chain. Corrections follow a repeating schedule of 64 minutes. In each corrected minute, only second 0 changes length. The block counts its own seconds and minutes, so the calendar that consumes the tick does not take part.

The same block also drives an open-drain style pin. With the frequency-test bit set, the pin carries a 512 Hz square wave from a counter of its own, so the calibration setting cannot disturb it. With the bit clear, the pin follows the output-level bit. A stop input freezes the whole chain. All widths are parameters: the prescale stage width, the upper stage width, seconds per minute, and the test half-period. A small configuration of the block therefore keeps every behaviour and runs in few cycles.

Top module: `caldiv_unit`

## Requirements
- R1: While reset is low, tick_o is 0. Right after reset, with the test bit set, the pin is released (pin_low_o = 0).
- R2: An uncorrected second lasts exactly 2^(PRE_W+HI_W) accepted enables (32768 by default).
- R3: tick_o is a single-clock pulse. It is set in the clock after the posedge that accepted the enable completing a second.
- R4: While stop_i is 1, no enable is accepted, no tick occurs, and the test pin holds its level. Counting resumes where it stopped.
- R5: Seconds run 0..SEC_PER_MIN-1 and minutes run 0..63. Second 0 of minute m is altered exactly when m < 2*mag, where mag is cal_i[4:0].
- R6: With cal_i[5] = 1 (positive), an altered second is shortened by 2^PRE_W enables (256 by default).
- R7: With cal_i[5] = 0 (negative), an altered second is lengthened by 2^(PRE_W-1) enables (128 by default).
- R8: A full 64-minute cycle lasts 64*SEC_PER_MIN*2^(PRE_W+HI_W) enables, less 2^(PRE_W+1)*mag for a positive value or plus 2^PRE_W*mag for a negative one.
- R9: cal_i is captured only at a minute boundary, and the value after reset is 0. The first minute after reset is therefore uncorrected, and a mid-minute change first applies in the following minute.
- R10: With ftest_i = 1, pin_low_o changes level after every 2^FT_HALF_W accepted enables (32 by default, giving 512 Hz). The calibration value has no effect on this spacing.
- R11: With ftest_i = 0, pin_low_o = 1 (drive low) when out_level_i = 0, and pin_low_o = 0 (released) when out_level_i = 1.
- R12: Only cycles with osc_en_i = 1 and stop_i = 0 advance the block, whatever the pattern of gaps between enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator count enable |
| cal_i | input | CAL_W+1 | Bit CAL_W is the sign (1 = positive), low bits are the magnitude |
| stop_i | input | 1 | Freezes divider, schedule and test counter |
| ftest_i | input | 1 | Selects the test square wave on the pin |
| out_level_i | input | 1 | Static pin level when the test wave is off |
| tick_o | output | 1 | One-clock pulse per second |
| pin_low_o | output | 1 | 1 = pull pin low, 0 = release |

## Verification
The hardest case to reach from the ports is a complete 64-minute schedule, in which the altered seconds must line up with the minute count and the latched calibration. In the bench, the block uses a 16-enable second and 2-second minutes, so one full cycle takes about two thousand clocks. The bench then sweeps both signs over boundary magnitudes (0, 1, 31 and values in between). For each, it checks the length of every second and the total for the cycle against arithmetic expectations. A change of calibration in the middle of a minute, stop windows and gapped enables are applied on top of this schedule.

// File: rtl/caldiv_pkg.sv
package caldiv_pkg;
  localparam int CAL_W = 5;

  typedef struct packed {
    logic             pos;
    logic [CAL_W-1:0] mag;
  } cal_t;
endpackage

// File: rtl/caldiv_div.sv
module caldiv_div #(
  parameter int PRE_W = 8,
  parameter int HI_W  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic alter_pos_i,
  input  logic alter_neg_i,
  output logic sec_end_o
);
  localparam logic [PRE_W:0]  PRE_MAX  = (PRE_W+1)'((1 << PRE_W) - 1);
  localparam logic [PRE_W:0]  PRE_LONG = (PRE_W+1)'((1 << PRE_W) - 1 + (1 << (PRE_W-1)));
  localparam logic [HI_W-1:0] HI_MAX   = '1;

  logic [PRE_W:0]  pre_q;
  logic [HI_W-1:0] hi_q;
  logic            last_stage, pre_wrap;
  logic [PRE_W:0]  pre_term;

  // positive: skip one prescale period; negative: stretch the final one by half
  assign last_stage = alter_pos_i ? (hi_q == HI_MAX - 1'b1) : (hi_q == HI_MAX);
  assign pre_term   = (alter_neg_i && hi_q == HI_MAX) ? PRE_LONG : PRE_MAX;
  assign pre_wrap   = (pre_q == pre_term);
  assign sec_end_o  = adv_i && pre_wrap && last_stage;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      hi_q  <= '0;
    end else if (adv_i) begin
      if (pre_wrap) begin
        pre_q <= '0;
        hi_q  <= last_stage ? '0 : hi_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/caldiv_sched.sv
module caldiv_sched
  import caldiv_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sec_end_i,
  input  logic [CAL_W:0] cal_i,
  output logic           alter_pos_o,
  output logic           alter_neg_o
);
  localparam int SEC_W = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MIN_W = CAL_W + 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  cal_t             cal_q;
  logic             alter;

  assign alter       = (sec_q == '0) && (min_q < {cal_q.mag, 1'b0});
  assign alter_pos_o = alter && cal_q.pos;
  assign alter_neg_o = alter && !cal_q.pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      cal_q <= '0;
    end else if (sec_end_i) begin
      if (sec_q == SEC_LAST) begin
        sec_q <= '0;
        min_q <= min_q + 1'b1;
        cal_q <= cal_t'(cal_i);
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/caldiv_pin.sv
module caldiv_pin #(
  parameter int FT_HALF_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic ftest_i,
  input  logic out_level_i,
  output logic pin_low_o
);
  logic ft_q;

  generate
    if (FT_HALF_W == 0) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ft_q <= 1'b0;
        else if (adv_i) ft_q <= ~ft_q;
      end
    end else begin : g_count
      logic [FT_HALF_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
          ft_q  <= 1'b0;
        end else if (adv_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '1) ft_q <= ~ft_q;
        end
      end
    end
  endgenerate

  assign pin_low_o = ftest_i ? ft_q : !out_level_i;
endmodule

// File: rtl/caldiv_unit.sv
module caldiv_unit
  import caldiv_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int HI_W        = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int FT_HALF_W   = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           osc_en_i,
  input  logic [CAL_W:0] cal_i,
  input  logic           stop_i,
  input  logic           ftest_i,
  input  logic           out_level_i,
  output logic           tick_o,
  output logic           pin_low_o
);
  logic adv, sec_end, alter_pos, alter_neg, tick_q;

  assign adv = osc_en_i && !stop_i;

  caldiv_div #(.PRE_W(PRE_W), .HI_W(HI_W)) u_div (
    .clk_i, .rst_ni, .adv_i(adv),
    .alter_pos_i(alter_pos), .alter_neg_i(alter_neg),
    .sec_end_o(sec_end)
  );

  caldiv_sched #(.SEC_PER_MIN(SEC_PER_MIN)) u_sched (
    .clk_i, .rst_ni, .sec_end_i(sec_end), .cal_i,
    .alter_pos_o(alter_pos), .alter_neg_o(alter_neg)
  );

  caldiv_pin #(.FT_HALF_W(FT_HALF_W)) u_pin (
    .clk_i, .rst_ni, .adv_i(adv), .ftest_i, .out_level_i, .pin_low_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= sec_end;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/caldiv_unit_chk.sv
module caldiv_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic osc_en_i,
  input logic stop_i,
  input logic ftest_i,
  input logic out_level_i,
  input logic tick_o,
  input logic pin_low_o
);
  a_r3_tick_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(osc_en_i && !stop_i));

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r4_stop_holds_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && ftest_i) ##1 ftest_i |-> $stable(pin_low_o));

  a_r10_pin_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_i && ftest_i) ##1 ftest_i |-> $stable(pin_low_o));

  a_r11_static_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ftest_i |-> (pin_low_o == !out_level_i));
endmodule

bind caldiv_unit caldiv_unit_chk u_chk (
  .clk_i, .rst_ni, .osc_en_i, .stop_i, .ftest_i, .out_level_i, .tick_o, .pin_low_o
);

// File: tb/caldiv_unit_tb.sv
module caldiv_unit_tb;
  localparam int PRE_W = 2, HI_W = 2, SPM = 2, FT_HALF_W = 1, CAL_W = 5;
  localparam int SEC_LEN = 1 << (PRE_W + HI_W);

  logic clk = 0, rst_n = 0, osc_en = 0, stop = 0, ftest = 0, out_lvl = 1;
  logic [CAL_W:0] cal = '0;
  logic tick, pin_low;

  always #5 clk = ~clk;

  caldiv_unit #(.PRE_W(PRE_W), .HI_W(HI_W), .SEC_PER_MIN(SPM), .FT_HALF_W(FT_HALF_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .cal_i(cal), .stop_i(stop),
    .ftest_i(ftest), .out_level_i(out_lvl), .tick_o(tick), .pin_low_o(pin_low)
  );

  int nvec = 0, nerr = 0;
  int acc = 0, tot = 0, last_len = 0, ticks = 0, m_sec = 0, m_min = 0, ft_acc = 0;
  logic [CAL_W:0] m_cal = '0;
  bit prev_tick = 0, ft_chk = 0, done = 0;
  logic prev_pin = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit m_alter();
    return (m_sec == 0) && (m_min < 2 * int'(m_cal[CAL_W-1:0]));
  endfunction

  function automatic int exp_len();
    if (!m_alter()) return SEC_LEN;
    return m_cal[CAL_W] ? SEC_LEN - (1 << PRE_W) : SEC_LEN + (1 << (PRE_W - 1));
  endfunction

  task automatic step(bit en);
    bit acc_en;
    int e;
    string req;
    osc_en = en;
    acc_en = en && !stop;
    @(posedge clk);
    #1;
    if (acc_en) begin acc++; ft_acc++; end
    if (tick && !acc_en) chk(0, "R3 R12 tick without accepted enable", 1, 0);
    if (tick && prev_tick) chk(0, "R3 tick wider than one clock", 2, 1);
    if (stop && tick) chk(0, "R4 tick while stopped", 1, 0);
    if (tick) begin
      e = exp_len();
      req = !m_alter() ? "R2 R5 plain second" :
            (m_cal[CAL_W] ? "R5 R6 shortened second" : "R5 R7 lengthened second");
      chk(acc == e, req, acc, e);
      last_len = acc; tot += acc; acc = 0; ticks++;
      if (m_sec == SPM - 1) begin
        m_sec = 0; m_min = (m_min + 1) % 64; m_cal = cal;
      end else m_sec++;
    end else if (acc > SEC_LEN + (1 << (PRE_W - 1))) begin
      chk(0, "R2 missing tick", acc, exp_len());
      acc = 0;
    end
    if (ftest && pin_low !== prev_pin) begin
      if (ft_chk) chk(ft_acc == (1 << FT_HALF_W), "R10 test toggle spacing", ft_acc, 1 << FT_HALF_W);
      ft_acc = 0;
    end
    prev_pin = pin_low;
    prev_tick = tick;
  endtask

  task automatic run_ticks(int n, int gap);
    int target = ticks + n;
    int i = 0;
    while (ticks < target) begin
      step((gap == 0) ? 1'b1 : ((i % gap) != 0));
      i++;
    end
  endtask

  task automatic do_reset(logic [CAL_W:0] c);
    rst_n = 0; cal = c; osc_en = 0; stop = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(tick == 0, "R1 tick idle in reset", tick, 0);
    rst_n = 1;
    acc = 0; tot = 0; ticks = 0; m_sec = 0; m_min = 0; m_cal = '0; ft_acc = 0;
    #1;
    prev_pin = pin_low; prev_tick = 0;
  endtask

  initial begin
    int mags[7] = '{0, 1, 2, 6, 15, 30, 31};
    logic held;
    ftest = 1;
    do_reset('0);
    chk(pin_low == 0, "R1 test pin released after reset", pin_low, 0);
    ftest = 0; out_lvl = 1; #1;
    chk(pin_low == 0, "R11 high level released", pin_low, 0);
    out_lvl = 0; #1;
    chk(pin_low == 1, "R11 low level driven", pin_low, 1);
    out_lvl = 1;

    foreach (mags[k]) begin
      for (int sg = 0; sg < 2; sg++) begin
        int e;
        do_reset({sg[0], 5'(mags[k])});
        run_ticks(1, 0);
        chk(last_len == SEC_LEN, "R9 first minute uncorrected", last_len, SEC_LEN);
        run_ticks(SPM - 1, 0);
        tot = 0;
        run_ticks(64 * SPM, 0);
        e = 64 * SPM * SEC_LEN + (sg ? -((1 << (PRE_W + 1)) * mags[k]) : (1 << PRE_W) * mags[k]);
        chk(tot == e, "R8 cycle total", tot, e);
      end
    end

    do_reset('0);
    run_ticks(SPM, 0);
    cal = {1'b0, 5'd31};
    run_ticks(1, 0);
    chk(last_len == SEC_LEN, "R9 change waits for boundary", last_len, SEC_LEN);
    run_ticks(SPM, 0);
    chk(last_len == SEC_LEN + (1 << (PRE_W - 1)), "R9 new value after boundary",
        last_len, SEC_LEN + (1 << (PRE_W - 1)));

    ftest = 1;
    do_reset({1'b1, 5'd3});
    ft_chk = 1;
    repeat (5) step(1);
    held = pin_low;
    stop = 1;
    repeat (40) step(1);
    chk(pin_low == held, "R4 pin frozen while stopped", pin_low, held);
    stop = 0;
    run_ticks(1, 0);
    chk(last_len == SEC_LEN, "R4 count resumes", last_len, SEC_LEN);
    run_ticks(SPM * 4, 0);
    run_ticks(SPM, 3);
    ft_chk = 0;

    ftest = 0;
    do_reset('0);
    run_ticks(2, 3);
    chk(last_len == SEC_LEN, "R12 gapped enables", last_len, SEC_LEN);
    do_reset({1'b0, 5'd1});
    run_ticks(SPM + 1, 2);
    chk(last_len == SEC_LEN + (1 << (PRE_W - 1)), "R12 gapped enables lengthened",
        last_len, SEC_LEN + (1 << (PRE_W - 1)));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nvec++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule